// File: doc/BRIEF.md
# Fused-Iteration Stencil Tile Engine

This block computes one tile of a one-dimensional array that is repeatedly smoothed by a three-point averaging stencil. After a start pulse it takes the tile's elements in through a burst load port. It then runs a fixed number of iterations on its own on-chip storage, which has two banks that trade the roles of old and new data each iteration. After every group of fused iterations, and after the final one, it writes its results out in a burst.

Neighbouring tiles swap edge values over FIFO-style valid/ready channels, one outgoing and one incoming on each side, so no redundant halo is recomputed. Within an iteration the engine first computes the interior elements, which need nothing from a neighbour, while the edge values are in flight. Only then does it compute the two end elements. An end element whose neighbour value is missing holds the pipeline until that value arrives.

Every iteration closes at a barrier shared with the peer tiles: the engine raises `done` and waits for `go`. A tile placed at the global array boundary is built with that side marked as an edge. On that side the element keeps its value and the channels stay idle.

Top module: `stencil_tile_engine`

## Requirements
- R1: While reset is applied and right after it, `busy`, `done`, `wb_valid`, `lo_valid`, `ro_valid`, `li_ready` and `ri_ready` are all low.
- R2: A `start` pulse in idle begins a run. The next TILE_LEN cycles with `ld_valid` high load elements 0 to TILE_LEN-1 in order. `busy` is high from the cycle after `start` until the barrier of the last of RUN_ITERS iterations is released.
- R3: Each iteration sets new[i] = floor((old[i-1] + old[i] + old[i+1]) / 3). It uses only the previous iteration's values, and a received edge value stands in for old[-1] or old[TILE_LEN].
- R4: On a side built as a global edge, the end element keeps its value in every iteration, and that side's `*_valid` out and `*_ready` in stay low.
- R5: In each iteration, on each non-edge side, the engine offers its current end element (old[0] left, old[TILE_LEN-1] right) exactly once. It holds valid with stable data until the offer is taken. It accepts exactly one incoming value per side, with ready high from the start of the compute phase until the value is taken.
- R6: An end element never uses an incoming value that has not arrived. If the value comes late, the iteration waits and `done` stays low, and the results are still correct.
- R7: An incoming edge value that arrives within the first TILE_LEN-3 cycles of ready does not lengthen the iteration, because interior elements are computed first.
- R8: After an iteration, `done` stays high until `go` is sampled high. Until then no edge value is offered and no write occurs.
- R9: After every FUSE_DEPTH-th iteration, and after the last one, the engine writes TILE_LEN elements on consecutive cycles with `wb_addr` 0 up to TILE_LEN-1 before `done` rises. Other iterations write nothing.
- R10: The averaging is exact across the full range of the data width, including all elements and neighbour values at the maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled in idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Iteration finished, waiting at barrier |
| go | input | 1 | Barrier release |
| ld_valid | input | 1 | Load data valid |
| ld_data | input | DW | Load data, element order |
| wb_valid | output | 1 | Writeback strobe |
| wb_addr | output | log2(TILE_LEN) | Writeback element index |
| wb_data | output | DW | Writeback element value |
| lo_valid | output | 1 | Left outgoing edge value valid |
| lo_ready | input | 1 | Left neighbour takes value |
| lo_data | output | DW | Left outgoing edge value |
| li_valid | input | 1 | Left incoming value valid |
| li_ready | output | 1 | Engine accepts left incoming value |
| li_data | input | DW | Left incoming value |
| ro_valid | output | 1 | Right outgoing edge value valid |
| ro_ready | input | 1 | Right neighbour takes value |
| ro_data | output | DW | Right outgoing edge value |
| ri_valid | input | 1 | Right incoming value valid |
| ri_ready | output | 1 | Engine accepts right incoming value |
| ri_data | input | DW | Right incoming value |

## Verification
The embedded properties check, on every cycle, that an outgoing edge value holds steady until it is taken. They also check that an incoming channel closes after one transfer, that writeback addresses advance by one without gaps, that the barrier holds with the exchange channels quiet, and that a start in idle raises busy.

The arithmetic itself cannot be seen by those properties, so the bench scenarios cover it. The same holds for interior-first ordering, which shows up only as equal iteration lengths under prompt and delayed edge values. The bench also covers the stall on a late neighbour value, the bank swap that keeps old and new data apart, and the fused writeback schedule including a final partial group.

// File: rtl/stencil_pkg.sv
`timescale 1ns/1ps
package stencil_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ARM,
    ST_COMP,
    ST_DRAIN,
    ST_WB,
    ST_BAR
  } eng_state_t;
endpackage

// File: rtl/stencil_avg3.sv
`timescale 1ns/1ps
module stencil_avg3 #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  output logic [DW-1:0] q
);
  localparam int SW = DW + 2;
  localparam int SH = SW + 1;
  localparam int PW = SW + SH;
  // reciprocal of three rounded up; exact floor for any sum below 2**SW
  localparam logic [PW-1:0] RECIP = PW'(((64'd1 << SH) + 64'd2) / 64'd3);

  logic [SW-1:0] sum;
  logic [PW-1:0] prod;

  assign sum  = SW'(a) + SW'(b) + SW'(c);
  assign prod = PW'(sum) * RECIP;
  assign q    = prod[SH +: DW];
endmodule

// File: rtl/stencil_edge_link.sv
`timescale 1ns/1ps
module stencil_edge_link #(
  parameter int DW      = 16,
  parameter bit IS_EDGE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [DW-1:0] edge_val,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  output logic [DW-1:0] halo,
  output logic          have_halo,
  output logic          tx_done
);
  generate
    if (IS_EDGE) begin : g_edge
      logic edge_unused;
      assign edge_unused = ^{clk, rst_n, arm, edge_val, tx_ready, rx_valid, rx_data};
      assign tx_valid  = 1'b0;
      assign tx_data   = '0;
      assign rx_ready  = 1'b0;
      assign halo      = '0;
      assign have_halo = 1'b1;
      assign tx_done   = 1'b1;
    end else begin : g_link
      logic          tx_pend, tx_pend_d;
      logic          rx_pend, rx_pend_d;
      logic [DW-1:0] tx_q, halo_q;

      always_comb begin
        tx_pend_d = tx_pend;
        rx_pend_d = rx_pend;
        if (tx_pend && tx_ready) tx_pend_d = 1'b0;
        if (rx_pend && rx_valid) rx_pend_d = 1'b0;
        if (arm) begin
          tx_pend_d = 1'b1;
          rx_pend_d = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tx_pend <= 1'b0;
          rx_pend <= 1'b0;
        end else begin
          tx_pend <= tx_pend_d;
          rx_pend <= rx_pend_d;
        end
      end

      always_ff @(posedge clk) begin
        if (arm) tx_q <= edge_val;
        if (rx_pend && rx_valid) halo_q <= rx_data;
      end

      assign tx_valid  = tx_pend;
      assign tx_data   = tx_q;
      assign rx_ready  = rx_pend;
      assign halo      = halo_q;
      assign have_halo = !rx_pend;
      assign tx_done   = !tx_pend;

      // R5
      tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
      // R5
      rx_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready |=> !rx_ready);
    end
  endgenerate
endmodule

// File: rtl/stencil_tile_engine.sv
`timescale 1ns/1ps
module stencil_tile_engine
  import stencil_pkg::*;
#(
  parameter int DW         = 16,
  parameter int TILE_LEN   = 8,
  parameter int FUSE_DEPTH = 2,
  parameter int RUN_ITERS  = 5,
  parameter bit LEFT_EDGE  = 1'b0,
  parameter bit RIGHT_EDGE = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  output logic                        busy,
  output logic                        done,
  input  logic                        go,
  input  logic                        ld_valid,
  input  logic [DW-1:0]               ld_data,
  output logic                        wb_valid,
  output logic [$clog2(TILE_LEN)-1:0] wb_addr,
  output logic [DW-1:0]               wb_data,
  output logic                        lo_valid,
  input  logic                        lo_ready,
  output logic [DW-1:0]               lo_data,
  input  logic                        li_valid,
  output logic                        li_ready,
  input  logic [DW-1:0]               li_data,
  output logic                        ro_valid,
  input  logic                        ro_ready,
  output logic [DW-1:0]               ro_data,
  input  logic                        ri_valid,
  output logic                        ri_ready,
  input  logic [DW-1:0]               ri_data
);
  localparam int AW  = $clog2(TILE_LEN);
  localparam int ITW = $clog2(RUN_ITERS) + 1;
  localparam int FW  = $clog2(FUSE_DEPTH) + 1;
  localparam logic [AW-1:0] LAST = AW'(TILE_LEN - 1);
  localparam logic [AW-1:0] NIND = AW'(TILE_LEN - 2);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  eng_state_t       state, state_d;
  logic             sel, sel_d;
  logic [AW-1:0]    cnt, cnt_d;
  logic [ITW-1:0]   iter, iter_d;
  logic [FW-1:0]    fcnt, fcnt_d;
  logic             arm;
  logic [DW-1:0]    mem [2][TILE_LEN];

  logic [AW-1:0]    e_idx, l_idx, r_idx;
  logic [DW-1:0]    old_l, old_c, old_r, avg_q, new_val;
  logic [DW-1:0]    halo_l, halo_r;
  logic             have_l, have_r, sent_l, sent_r;
  logic             el_ready, hold_el, comp_fire, ld_we, wb_due, last_iter;

  // interior elements first, then element 0, then the last element
  always_comb begin
    if (cnt < NIND)       e_idx = cnt + 1'b1;
    else if (cnt == NIND) e_idx = '0;
    else                  e_idx = LAST;
  end
  assign l_idx = (e_idx == '0)  ? e_idx : e_idx - 1'b1;
  assign r_idx = (e_idx == LAST) ? e_idx : e_idx + 1'b1;

  assign old_c = mem[sel][e_idx];
  assign old_l = (e_idx == '0)  ? halo_l : mem[sel][l_idx];
  assign old_r = (e_idx == LAST) ? halo_r : mem[sel][r_idx];

  stencil_avg3 #(.DW(DW)) u_avg (.a(old_l), .b(old_c), .c(old_r), .q(avg_q));

  assign hold_el  = ((e_idx == '0) && LEFT_EDGE) || ((e_idx == LAST) && RIGHT_EDGE);
  assign new_val  = hold_el ? old_c : avg_q;
  assign el_ready = (e_idx == '0) ? have_l : ((e_idx == LAST) ? have_r : 1'b1);
  assign comp_fire = (state == ST_COMP) && el_ready;
  assign ld_we     = (state == ST_LOAD) && ld_valid;
  assign last_iter = (iter == ITW'(RUN_ITERS - 1));
  assign wb_due    = (fcnt == FW'(FUSE_DEPTH - 1)) || last_iter;

  stencil_edge_link #(.DW(DW), .IS_EDGE(LEFT_EDGE)) u_left (
    .clk(clk), .rst_n(rst_int_n), .arm(arm), .edge_val(mem[sel][0]),
    .tx_valid(lo_valid), .tx_ready(lo_ready), .tx_data(lo_data),
    .rx_valid(li_valid), .rx_ready(li_ready), .rx_data(li_data),
    .halo(halo_l), .have_halo(have_l), .tx_done(sent_l));

  stencil_edge_link #(.DW(DW), .IS_EDGE(RIGHT_EDGE)) u_right (
    .clk(clk), .rst_n(rst_int_n), .arm(arm), .edge_val(mem[sel][LAST]),
    .tx_valid(ro_valid), .tx_ready(ro_ready), .tx_data(ro_data),
    .rx_valid(ri_valid), .rx_ready(ri_ready), .rx_data(ri_data),
    .halo(halo_r), .have_halo(have_r), .tx_done(sent_r));

  always_comb begin
    state_d = state;
    sel_d   = sel;
    cnt_d   = cnt;
    iter_d  = iter;
    fcnt_d  = fcnt;
    arm     = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        state_d = ST_LOAD;
        cnt_d   = '0;
        iter_d  = '0;
        fcnt_d  = '0;
      end
      ST_LOAD: if (ld_valid) begin
        cnt_d = cnt + 1'b1;
        if (cnt == LAST) begin
          cnt_d   = '0;
          state_d = ST_ARM;
        end
      end
      ST_ARM: begin
        arm     = 1'b1;
        cnt_d   = '0;
        state_d = ST_COMP;
      end
      ST_COMP: if (comp_fire) begin
        cnt_d = cnt + 1'b1;
        if (cnt == LAST) begin
          cnt_d   = '0;
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: if (sent_l && sent_r) begin
        sel_d   = ~sel;
        fcnt_d  = wb_due ? '0 : fcnt + 1'b1;
        state_d = wb_due ? ST_WB : ST_BAR;
      end
      ST_WB: begin
        cnt_d = cnt + 1'b1;
        if (cnt == LAST) begin
          cnt_d   = '0;
          state_d = ST_BAR;
        end
      end
      ST_BAR: if (go) begin
        if (last_iter) state_d = ST_IDLE;
        else begin
          iter_d  = iter + 1'b1;
          state_d = ST_ARM;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state <= ST_IDLE;
      sel   <= 1'b0;
      cnt   <= '0;
      iter  <= '0;
      fcnt  <= '0;
    end else begin
      state <= state_d;
      sel   <= sel_d;
      cnt   <= cnt_d;
      iter  <= iter_d;
      fcnt  <= fcnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_we)     mem[sel][cnt]    <= ld_data;
    if (comp_fire) mem[~sel][e_idx] <= new_val;
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_BAR);
  assign wb_valid = (state == ST_WB);
  assign wb_addr  = cnt;
  assign wb_data  = mem[sel][cnt];

  // R9
  wb_burst_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    wb_valid && (wb_addr != LAST) |=> wb_valid && (wb_addr == $past(wb_addr) + 1'b1));
  // R8
  bar_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done && !go |=> done);
  // R8
  bar_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> !ro_valid && !lo_valid);
  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    start && !busy |=> busy);
endmodule

// File: tb/stencil_tile_engine_tb_top.sv
`timescale 1ns/1ps
module stencil_tile_engine_tb_top;
  localparam int DW = 16;
  localparam int N  = 8;
  localparam int FD = 2;
  localparam int IT = 5;
  localparam int NV = 4;

  localparam logic [15:0] VEC_INIT [NV][N] = '{
    '{16'd10, 16'd20, 16'd30, 16'd40, 16'd50, 16'd60, 16'd70, 16'd80},
    '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    '{16'd0, 16'hFFFF, 16'd0, 16'hFFFF, 16'd0, 16'hFFFF, 16'd0, 16'hFFFF},
    '{16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd7, 16'd8}
  };
  localparam logic [15:0] VEC_HALO [NV] = '{16'd100, 16'hFFFF, 16'd0, 16'd9};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, start, go, ld_valid;
  logic [DW-1:0] ld_data;
  logic          busy, done, wb_valid;
  logic [2:0]    wb_addr;
  logic [DW-1:0] wb_data, lo_data, ro_data;
  logic          lo_valid, li_ready, ro_valid, ri_ready;
  logic          ri_valid;
  logic [DW-1:0] ri_data;

  stencil_tile_engine #(.DW(DW), .TILE_LEN(N), .FUSE_DEPTH(FD), .RUN_ITERS(IT),
                        .LEFT_EDGE(1'b1), .RIGHT_EDGE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .go(go),
    .ld_valid(ld_valid), .ld_data(ld_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .lo_valid(lo_valid), .lo_ready(1'b1), .lo_data(lo_data),
    .li_valid(1'b0), .li_ready(li_ready), .li_data('0),
    .ro_valid(ro_valid), .ro_ready(1'b1), .ro_data(ro_data),
    .ri_valid(ri_valid), .ri_ready(ri_ready), .ri_data(ri_data));

  int nchk = 0;
  int nfail = 0;
  logic [15:0] A [N];
  logic [15:0] Nw [N];
  int lens [IT];
  int ref_lens [IT];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_job(input int v, input int rdly, input int gdly);
    for (int k = 0; k < N; k++) A[k] = VEC_INIT[v][k];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    for (int k = 0; k < N; k++) begin
      ld_valid = 1'b1; ld_data = A[k];
      @(negedge clk);
    end
    ld_valid = 1'b0;
    for (int it = 0; it < IT; it++) begin
      logic [15:0] halo;
      bit due, given, fin;
      int wbn, ron, cyc, seen, bad;
      halo = VEC_HALO[v];
      Nw[0] = A[0];
      for (int i = 1; i < N - 1; i++)
        Nw[i] = 16'((int'(A[i-1]) + int'(A[i]) + int'(A[i+1])) / 3);
      Nw[N-1] = 16'((int'(A[N-2]) + int'(A[N-1]) + int'(halo)) / 3);
      due = (((it + 1) % FD) == 0) || (it == IT - 1);
      wbn = 0; ron = 0; cyc = 0; seen = -1; bad = 0; given = 1'b0; fin = 1'b0;
      while (!fin && cyc < 400) begin
        @(negedge clk); cyc++;
        if (ri_valid) begin ri_valid = 1'b0; given = 1'b1; end
        if (!given && ri_ready) begin
          if (seen < 0) seen = cyc;
          if (cyc - seen >= rdly) begin ri_valid = 1'b1; ri_data = halo; end
        end
        if (lo_valid || li_ready) bad++;
        if (ro_valid) begin
          ron++;
          chk(ro_data == A[N-1], "R5 outgoing edge value", int'(ro_data), int'(A[N-1]));
        end
        if (wb_valid) begin
          chk(due, "R9 write only when due", 1, int'(due));
          chk(int'(wb_addr) == wbn, "R9 writeback address order", int'(wb_addr), wbn);
          if (wbn < N)
            chk(wb_data == Nw[wbn], (wbn == 0) ? "R4 boundary hold" :
                ((wbn == N - 1) ? "R6 dependent element" : "R3/R10 interior value"),
                int'(wb_data), int'(Nw[wbn]));
          wbn++;
        end
        if (done) fin = 1'b1;
      end
      chk(fin, "R8 done reached", int'(fin), 1);
      chk(given, "R6 no done before edge value", int'(given), 1);
      chk(wbn == (due ? N : 0), "R9 writeback count", wbn, due ? N : 0);
      chk(ron == 1, "R5 single offer", ron, 1);
      chk(bad == 0, "R4 edge side idle", bad, 0);
      chk(busy == 1'b1, "R2 busy in run", int'(busy), 1);
      lens[it] = cyc;
      for (int g = 0; g < gdly; g++) begin
        @(negedge clk);
        chk(done && !ro_valid && !wb_valid, "R8 barrier holds", int'(done), 1);
      end
      go = 1'b1;
      @(negedge clk); go = 1'b0;
      for (int k = 0; k < N; k++) A[k] = Nw[k];
    end
    chk(busy == 1'b0, "R2 busy drops after run", int'(busy), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; go = 1'b0; ld_valid = 1'b0; ld_data = '0;
    ri_valid = 1'b0; ri_data = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wb_valid && !lo_valid && !ro_valid && !li_ready && !ri_ready,
        "R1 outputs in reset", int'(busy | done | wb_valid | ro_valid | ri_ready), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !wb_valid && !ro_valid && !ri_ready,
        "R1 outputs after reset", int'(busy | done | wb_valid | ro_valid | ri_ready), 0);

    // table walk
    for (int v = 0; v < NV; v++) run_job(v, 0, 2);

    // R7: late-but-early-enough edge value costs no cycles
    run_job(0, 0, 1);
    for (int i = 0; i < IT; i++) ref_lens[i] = lens[i];
    run_job(0, N - 4, 1);
    for (int i = 0; i < IT; i++)
      chk(lens[i] == ref_lens[i], "R7 iteration length", lens[i], ref_lens[i]);

    // R6: very late edge value stalls the iteration
    run_job(3, 30, 1);
    chk(lens[IT-1] > ref_lens[IT-1], "R6 stall lengthens iteration", lens[IT-1], ref_lens[IT-1] + 1);

    // R8: long barrier wait
    run_job(2, 0, 12);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule